// File: doc/BRIEF.md
# Streaming Running-Sum Accumulator

This block takes one data word on every clock cycle and reports the running total of every word it has accepted since the last reset or clear. Each addition has a latency of several cycles, so a single register folded back through one adder cannot take a new word each cycle. The block instead keeps `LAT` interleaved partial sums in a circulating ring, one per adder slot. Each partial sum comes back out of the adder just in time to take its next word. A pipelined tree of two-input adders then combines the partial sums into the total.

No sequencer controls the flow. A valid flag travels beside the data through a delay line that is exactly as deep as the reduction tree, so the output valid flag marks the cycles whose total includes a newly accepted word. A synchronous clear empties the ring, the tree and the valid line in one cycle. Arithmetic wraps modulo 2^W, so the order in which the ring and the tree combine terms never changes the result.

Top module: `running_sum_acc`

## Requirements
- R1: A word presented with `in_valid_i` high is accepted on every cycle. There is no stall and no ready signal, so back-to-back valid words are all counted.
- R2: With DLY = ceil(log2(LAT)) * LAT, the value of `out_sum_o` after clock edge e equals the sum of all words accepted from the last reset or clear up to and including edge e-DLY.
- R3: On a cycle with `in_valid_i` low, `in_data_i` is ignored and adds nothing to the total.
- R4: After edge e, `out_valid_o` equals `in_valid_i` as sampled at edge e-DLY, provided there was no clear or reset in the edges e-DLY through e.
- R5: When `clear_i` is sampled high, `out_sum_o` and `out_valid_o` are 0 after that same edge. They stay 0 until words accepted later reach the output. A word sampled in the same cycle as `clear_i` is dropped.
- R6: When `rst_n` (active low, synchronous) is sampled low, `out_sum_o` and `out_valid_o` are 0 after that edge.
- R7: The total wraps modulo 2^W. A sum past the top of the range continues from zero.
- R8: `LAT` values that are not a power of two give correct totals. The unused tree inputs are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all partial sums and pipeline stages |
| in_valid_i | input | 1 | The word on `in_data_i` is to be accumulated |
| in_data_i | input | W | Input word |
| out_valid_o | output | 1 | Delayed copy of the accepted-word flag |
| out_sum_o | output | W | Running total, DLY cycles behind the input |

## Verification
The bench builds the block with W = 16 and LAT = 3. The narrow width lets random 16-bit words wrap the total many times within a short run. A latency of three leaves one of the four tree inputs padded with zero, and it gives a delay of six edges that is not a power of two. A clear lands at random, sometimes inside that six-edge window, which exercises the case where a clear overtakes words that are still in flight.

// File: rtl/rsum_pkg.sv
package rsum_pkg;

    // Number of two-input adder levels needed to reduce n partial sums.
    function automatic int tree_levels(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Leaf count of the balanced tree (n rounded up to a power of two).
    function automatic int tree_leaves(input int n);
        return 1 << tree_levels(n);
    endfunction

    // Edges from an accepted word to its appearance on the output.
    function automatic int total_delay(input int lat);
        return tree_levels(lat) * lat;
    endfunction

endpackage

// File: rtl/rsum_pipe_add.sv
// Two-input adder with LAT register stages; the sum is formed at the
// first stage and carried through the rest.
module rsum_pipe_add #(
    parameter int W   = 32,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [LAT-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= a_i + b_i;
            for (int i = 1; i < LAT; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sum_o = stage_q[LAT-1];
endmodule

// File: rtl/rsum_slot_ring.sv
// Feedback adder of latency LAT whose pipeline holds LAT interleaved
// partial sums; word k joins the partial sum that leaves the ring at
// the same edge, so slot rotation needs no index logic.
module rsum_slot_ring #(
    parameter int W   = 32,
    parameter int LAT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [W-1:0]          term_i,
    output logic [LAT-1:0][W-1:0] slots_o
);
    logic [LAT-1:0][W-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ring_q <= '0;
        end else begin
            ring_q[0] <= term_i + ring_q[LAT-1];
            for (int i = 1; i < LAT; i++) begin
                ring_q[i] <= ring_q[i-1];
            end
        end
    end

    assign slots_o = ring_q;
endmodule

// File: rtl/rsum_reduce_tree.sv
// Balanced tree of pipelined two-input adders; missing leaves are zero.
module rsum_reduce_tree
    import rsum_pkg::*;
#(
    parameter int W   = 32,
    parameter int N   = 4,
    parameter int LAT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [N-1:0][W-1:0] leaves_i,
    output logic [W-1:0]        total_o
);
    localparam int P     = tree_leaves(N);
    localparam int NODES = 2 * P - 1;

    // Heap layout: node 0 is the root, nodes P-1 .. 2P-2 are leaves.
    logic [W-1:0] node [NODES];

    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign node[P-1+j] = leaves_i[j];
        end else begin : g_pad
            assign node[P-1+j] = '0;
        end
    end

    for (genvar k = 0; k < P - 1; k++) begin : g_add
        rsum_pipe_add #(.W(W), .LAT(LAT)) u_add (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .a_i   (node[2*k+1]),
            .b_i   (node[2*k+2]),
            .sum_o (node[k])
        );
    end

    assign total_o = node[0];
endmodule

// File: rtl/rsum_valid_delay.sv
// Predicate delay line that matches the reduction tree depth.
module rsum_valid_delay #(
    parameter int DEPTH = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic v_i,
    output logic v_o
);
    logic [DEPTH-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            line_q <= '0;
        end else begin
            line_q <= {line_q[DEPTH-2:0], v_i};
        end
    end

    assign v_o = line_q[DEPTH-1];
endmodule

// File: rtl/running_sum_acc.sv
module running_sum_acc
    import rsum_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_data_i,
    output logic         out_valid_o,
    output logic [W-1:0] out_sum_o
);
    localparam int DLY = total_delay(LAT);

    logic [W-1:0]          term;
    logic [LAT-1:0][W-1:0] slot_q;

    // An idle cycle feeds zero; the ring still rotates.
    assign term = in_valid_i ? in_data_i : '0;

    rsum_slot_ring #(.W(W), .LAT(LAT)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clear_i),
        .term_i  (term),
        .slots_o (slot_q)
    );

    rsum_reduce_tree #(.W(W), .N(LAT), .LAT(LAT)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clear_i),
        .leaves_i (slot_q),
        .total_o  (out_sum_o)
    );

    // One extra stage covers the ring register ahead of the tree.
    rsum_valid_delay #(.DEPTH(DLY + 1)) u_vdly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_i),
        .v_i   (in_valid_i),
        .v_o   (out_valid_o)
    );
endmodule

// File: rtl/rsum_checker.sv
module rsum_checker
    import rsum_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clear_i,
    input logic                  in_valid_i,
    input logic [W-1:0]          in_data_i,
    input logic                  out_valid_o,
    input logic [W-1:0]          out_sum_o,
    input logic [LAT-1:0][W-1:0] slots
);
    localparam int DLY = total_delay(LAT);
    localparam int CW  = $clog2(DLY + 2) + 1;

    logic [W-1:0]  ring_sum;
    logic [CW-1:0] since_acc;

    always_comb begin
        ring_sum = '0;
        for (int i = 0; i < LAT; i++) begin
            ring_sum = ring_sum + slots[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            since_acc <= CW'(DLY + 1);
        end else if (in_valid_i) begin
            since_acc <= '0;
        end else if (since_acc <= CW'(DLY)) begin
            since_acc <= since_acc + 1'b1;
        end
    end

    // R2 / R7: an accepted word raises the ring total by exactly that word, modulo 2^W
    a_r2_ring_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !clear_i) |=> (ring_sum == W'($past(ring_sum) + $past(in_data_i))));

    // R3: an idle cycle leaves the ring total unchanged
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid_i && !clear_i) |=> $stable(ring_sum));

    // R4: an output valid needs an accepted word no more than DLY edges back
    a_r4_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (since_acc <= CW'(DLY)));

    // R5: clear empties the output and the ring within one cycle
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (out_sum_o == '0 && !out_valid_o && ring_sum == '0));

    // R6: reset state of the outputs
    a_r6_reset_state: assert property (@(posedge clk)
        !rst_n |=> (out_sum_o == '0 && !out_valid_o));
endmodule

bind running_sum_acc rsum_checker #(.W(W), .LAT(LAT)) u_rsum_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_sum_o   (out_sum_o),
    .slots       (slot_q)
);

// File: tb/running_sum_acc_test.sv
module running_sum_acc_test;
    localparam int W        = 16;
    localparam int LAT      = 3;
    localparam int DLY      = 6;       // ceil(log2(3)) * 3
    localparam int HIST     = 64;
    localparam int CLK_PER  = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear_i = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [W-1:0] in_data_i = '0;
    logic         out_valid_o;
    logic [W-1:0] out_sum_o;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    bit done   = 1'b0;

    logic [W-1:0] tot = '0;
    logic [W-1:0] tot_h [HIST];
    bit           vv_h  [HIST];
    bit           clr_h [HIST];

    running_sum_acc #(.W(W), .LAT(LAT)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .out_valid_o (out_valid_o),
        .out_sum_o   (out_sum_o)
    );

    always #(CLK_PER / 2) clk = ~clk;

    // Reference model: running total and flags per edge.
    always @(posedge clk) begin
        bit c;
        int ix;
        edge_n = edge_n + 1;
        ix = edge_n % HIST;
        c = !rst_n || clear_i;
        if (c) tot = '0;
        else if (in_valid_i) tot = tot + in_data_i;
        tot_h[ix] = tot;
        vv_h[ix]  = !c && in_valid_i;
        clr_h[ix] = c;
    end

    function automatic bit cleared_in_window(input int e);
        for (int k = e - DLY + 1; k <= e; k++) begin
            if (k <= 0 || clr_h[k % HIST]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [W-1:0] exp_sum(input int e);
        if (cleared_in_window(e) || e - DLY <= 0) return '0;
        return tot_h[(e - DLY) % HIST];
    endfunction

    function automatic bit exp_valid(input int e);
        if (cleared_in_window(e) || e - DLY <= 0) return 1'b0;
        return vv_h[(e - DLY) % HIST];
    endfunction

    task automatic check_out(input string tag);
        logic [W-1:0] es;
        bit           ev;
        es = exp_sum(edge_n);
        ev = exp_valid(edge_n);
        checks++;
        if (out_sum_o !== es) begin
            fails++;
            $display("FAIL %s sum edge %0d: got %0h expected %0h", tag, edge_n, out_sum_o, es);
        end
        checks++;
        if (out_valid_o !== ev) begin
            fails++;
            $display("FAIL R4 valid (%s) edge %0d: got %0b expected %0b", tag, edge_n, out_valid_o, ev);
        end
    endtask

    // Check the outputs of the previous edge, then drive the next inputs.
    task automatic step(input bit v, input logic [W-1:0] d, input bit c, input string tag);
        @(negedge clk);
        check_out(tag);
        in_valid_i = v;
        in_data_i  = d;
        clear_i    = c;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R6: reset state
        repeat (3) begin
            @(negedge clk);
        end
        checks++;
        if (out_sum_o !== '0 || out_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R6 reset: got sum %0h valid %0b expected 0 0", out_sum_o, out_valid_o);
        end
        rst_n = 1'b1;
        // R1 / R2: back-to-back ramp
        for (int i = 1; i <= 20; i++) step(1'b1, W'(i), 1'b0, "R1");
        for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b0, "R2");
        // R3: idle cycles with junk data
        for (int i = 0; i < 12; i++) step(i[0], 16'hBEEF, 1'b0, "R3");
        for (int i = 0; i < 8; i++) step(1'b0, 16'hDEAD, 1'b0, "R3");
        // R7: wraparound
        for (int i = 0; i < 10; i++) step(1'b1, 16'hFFF0, 1'b0, "R7");
        for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b0, "R7");
        // R5: clear mid-stream, with a word in the clear cycle
        for (int i = 0; i < 3; i++) step(1'b1, 16'h0100, 1'b0, "R5");
        step(1'b1, 16'h7777, 1'b1, "R5");
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0003, 1'b0, "R5");
        step(1'b0, '0, 1'b1, "R5");
        for (int i = 0; i < 10; i++) step(1'b0, 16'h1234, 1'b0, "R5");
        // R6: reset mid-stream
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0011, 1'b0, "R6");
        @(negedge clk);
        check_out("R6");
        rst_n = 1'b0;
        step(1'b1, 16'h0022, 1'b0, "R6");
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) step(1'b1, 16'h0005, 1'b0, "R6");
        // R8 / R2: random traffic on a non power-of-two ring
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, W'($urandom), ($urandom % 64) == 0, "R8");
        end
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b0, "R2");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule